// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block is the bus-side instruction queue of a 16-bit processor. It keeps its own fetch pointer and asks the bus for code words while the queue has room. The returned words go into a small byte FIFO, and the decode side takes them out one byte per cycle through a valid/ready pair. Fetching runs in parallel with decode, so the queue refills while older bytes are consumed.

A control transfer pulses `flush` with the new instruction pointer on `flush_target`. The queue empties, any fetch already granted has its data thrown away, and fetching restarts at the target. Bus words are always fetched from an even address. When the target is odd, the first word is fetched from the even address just below it and only its upper byte is kept. A parameter selects a narrow-bus build with a 4-byte queue and single-byte fetches.

The fetch controller is a four-state machine. FS_IDLE goes to FS_REQ when enough slots are free. FS_REQ holds the request until it is granted, then goes to FS_WAIT. FS_WAIT goes back to FS_IDLE when the data arrives. FS_DROP waits out a fetch whose data must be discarded and then goes to FS_IDLE.

A flush sends FS_REQ-with-grant, FS_WAIT without data, and FS_DROP without data to FS_DROP. It sends every other case to FS_IDLE.

Top module: `insn_prefetch_queue`

## Requirements
- R1: After reset the queue is empty (`out_valid` low) and the first request is issued at `RESET_PTR` (default 16'hFFF0).
- R2: Bytes leave in ascending address order. Of each fetched word, `fetch_rdata[7:0]` (the byte at the even address) leaves first and `fetch_rdata[15:8]` leaves next.
- R3: Each granted fetch advances the fetch address by 2 in the wide build. A new request's address is the address that follows the last byte held.
- R4: In the wide build the queue holds at most 6 bytes. A request is raised only when at least 2 slots are free, so with 5 or 6 bytes held no request is raised.
- R5: An ungranted request stays asserted with an unchanged address until `fetch_gnt` is seen, unless a flush intervenes.
- R6: A flush empties the queue, so `out_valid` is low in the cycle after the flush.
- R7: Data of a fetch granted before or during the flush cycle is discarded, and the next request is at `flush_target`.
- R8: With an odd target (bit 0 set) in the wide build, the first request is at target-1 and only `fetch_rdata[15:8]` is queued. The next request is at target+1.
- R9: Fetching overlaps consumption. A push and a pop in the same cycle both take effect, and the byte stream stays correct whether `out_ready` is held high or toggles.
- R10: With `NARROW`=1 the queue holds 4 bytes and each fetch returns one byte on `fetch_rdata[7:0]`, with the address stepping by 1. With no consumption from reset, exactly 4 fetches are made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Control transfer: drop queue and restart fetching |
| flush_target | input | PTR_W | New instruction pointer for the flush |
| fetch_req | output | 1 | Fetch request toward the bus |
| fetch_addr | output | PTR_W | Address of the requested fetch |
| fetch_gnt | input | 1 | Bus accepts the pending request |
| fetch_rvalid | input | 1 | Fetched data is on fetch_rdata (one cycle) |
| fetch_rdata | input | WORD_W | Fetched word (narrow build uses bits 7:0) |
| out_valid | output | 1 | A byte is available to decode |
| out_byte | output | 8 | Oldest queued byte |
| out_ready | input | 1 | Decode takes the byte this cycle |

## Verification
The hardest situation to reach from the ports is a flush that lands while a granted fetch is still outstanding. The bench creates it by stretching the bus model's return latency to six cycles. It watches for the grant on the bus side and pulses the flush on the next cycle. The stale word then returns into FS_DROP. Checking the first byte after the restart, together with the next request address, shows that the stale word was discarded.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_REQ  = 2'd1,
        FS_WAIT = 2'd2,
        FS_DROP = 2'd3
    } fetch_state_t;
endpackage

// File: rtl/pfq_byte_fifo.sv
module pfq_byte_fifo #(
    parameter int DEPTH = 6,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [1:0]       push_n,
    input  logic [7:0]       push_b0,
    input  logic [7:0]       push_b1,
    input  logic             pop_req,
    output logic [7:0]       head,
    output logic [CNT_W-1:0] count
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [IDX_W+1:0] DEPTH_W = (IDX_W + 2)'(DEPTH);

    logic [IDX_W-1:0]   rd_idx, wr_idx, wr_idx1;
    logic [DEPTH*8-1:0] slot_flat;
    logic               do_pop;

    function automatic logic [IDX_W-1:0] idx_add(input logic [IDX_W-1:0] idx,
                                                 input logic [1:0] n);
        logic [IDX_W+1:0] s;
        s = {2'b00, idx} + {{IDX_W{1'b0}}, n};
        if (s >= DEPTH_W) s = s - DEPTH_W;
        return s[IDX_W-1:0];
    endfunction

    assign do_pop  = pop_req && (count != '0);
    assign wr_idx1 = idx_add(wr_idx, 2'd1);
    assign head    = slot_flat[rd_idx*8 +: 8];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (!clear) begin
                if (push_n != 2'd0 && wr_idx == IDX_W'(i))
                    q <= push_b0;
                else if (push_n == 2'd2 && wr_idx1 == IDX_W'(i))
                    q <= push_b1;
            end
        end
        assign slot_flat[i*8 +: 8] = q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rd_idx <= '0;
            wr_idx <= '0;
            count  <= '0;
        end else begin
            rd_idx <= do_pop ? idx_add(rd_idx, 2'd1) : rd_idx;
            wr_idx <= idx_add(wr_idx, push_n);
            count  <= count + CNT_W'(push_n) - CNT_W'(do_pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |-> ({1'b0, count} + (CNT_W + 1)'(push_n)) <= (CNT_W + 1)'(DEPTH) + (CNT_W + 1)'(do_pop)); // R4
endmodule

// File: rtl/pfq_fetch_ctrl.sv
module pfq_fetch_ctrl
    import pfq_pkg::*;
#(
    parameter int               PTR_W     = 16,
    parameter int               WORD_W    = 16,
    parameter bit               WIDE      = 1'b1,
    parameter logic [PTR_W-1:0] RESET_PTR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              space_ok,
    input  logic              flush,
    input  logic [PTR_W-1:0]  flush_target,
    input  logic              fetch_gnt,
    input  logic              fetch_rvalid,
    input  logic [WORD_W-1:0] fetch_rdata,
    output logic              fetch_req,
    output logic [PTR_W-1:0]  fetch_addr,
    output logic [1:0]        push_n,
    output logic [7:0]        push_b0,
    output logic [7:0]        push_b1
);
    localparam logic [PTR_W-1:0] STEP = WIDE ? PTR_W'(2) : PTR_W'(1);

    fetch_state_t     state_q, state_d;
    logic [PTR_W-1:0] ptr_q, ptr_d, base_addr;
    logic             skip_q, skip_d;

    assign base_addr = WIDE ? {ptr_q[PTR_W-1:1], 1'b0} : ptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
            ptr_q   <= RESET_PTR;
            skip_q  <= WIDE && RESET_PTR[0];
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            skip_q  <= skip_d;
        end
    end

    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        skip_d  = skip_q;
        if (flush) begin
            ptr_d  = flush_target;
            skip_d = WIDE && flush_target[0];
            unique case (state_q)
                FS_REQ:           state_d = fetch_gnt ? FS_DROP : FS_IDLE;
                FS_WAIT, FS_DROP: state_d = fetch_rvalid ? FS_IDLE : FS_DROP;
                default:          state_d = FS_IDLE;
            endcase
        end else begin
            unique case (state_q)
                FS_IDLE: if (space_ok) state_d = FS_REQ;
                FS_REQ: if (fetch_gnt) begin
                    state_d = FS_WAIT;
                    ptr_d   = base_addr + STEP;
                end
                FS_WAIT: if (fetch_rvalid) begin
                    state_d = FS_IDLE;
                    skip_d  = 1'b0;
                end
                FS_DROP: if (fetch_rvalid) state_d = FS_IDLE;
                default: state_d = FS_IDLE;
            endcase
        end
    end

    always_comb begin
        fetch_req  = (state_q == FS_REQ);
        fetch_addr = base_addr;
        push_n     = 2'd0;
        push_b0    = fetch_rdata[7:0];
        push_b1    = fetch_rdata[WORD_W-1 -: 8];
        if (state_q == FS_WAIT && fetch_rvalid && !flush) begin
            if (!WIDE) begin
                push_n = 2'd1;
            end else if (skip_q) begin
                push_n  = 2'd1;
                push_b0 = fetch_rdata[WORD_W-1 -: 8];
            end else begin
                push_n = 2'd2;
            end
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && !fetch_gnt && !flush |=> fetch_req && $stable(fetch_addr)); // R5
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && fetch_gnt && !flush |=> ptr_q == $past(fetch_addr) + STEP); // R3

    if (WIDE) begin : g_align_chk
        AST_EVEN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
            fetch_req |-> !fetch_addr[0]); // R8
    end
endmodule

// File: rtl/insn_prefetch_queue.sv
module insn_prefetch_queue #(
    parameter int               PTR_W     = 16,
    parameter int               WORD_W    = 16,
    parameter bit               NARROW    = 1'b0,
    parameter logic [PTR_W-1:0] RESET_PTR = PTR_W'('hFFF0)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [PTR_W-1:0]  flush_target,
    output logic              fetch_req,
    output logic [PTR_W-1:0]  fetch_addr,
    input  logic              fetch_gnt,
    input  logic              fetch_rvalid,
    input  logic [WORD_W-1:0] fetch_rdata,
    output logic              out_valid,
    output logic [7:0]        out_byte,
    input  logic              out_ready
);
    localparam bit WIDE      = !NARROW;
    localparam int BUS_BYTES = NARROW ? 1 : 2;
    localparam int DEPTH     = NARROW ? 4 : 6;
    localparam int CNT_W     = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] SPACE_LIM = CNT_W'(DEPTH - BUS_BYTES);

    logic [CNT_W-1:0] count;
    logic [1:0]       push_n;
    logic [7:0]       push_b0, push_b1;
    logic             space_ok;

    assign space_ok  = (count <= SPACE_LIM);
    assign out_valid = (count != '0);

    pfq_fetch_ctrl #(
        .PTR_W(PTR_W), .WORD_W(WORD_W), .WIDE(WIDE), .RESET_PTR(RESET_PTR)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .space_ok(space_ok), .flush(flush),
        .flush_target(flush_target), .fetch_gnt(fetch_gnt),
        .fetch_rvalid(fetch_rvalid), .fetch_rdata(fetch_rdata),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .push_n(push_n), .push_b0(push_b0), .push_b1(push_b1)
    );

    pfq_byte_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clear(flush), .push_n(push_n),
        .push_b0(push_b0), .push_b1(push_b1), .pop_req(out_ready),
        .head(out_byte), .count(count)
    );

    AST_REQ_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> count <= SPACE_LIM); // R4
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid); // R6
endmodule

// File: tb/sim_insn_prefetch_queue.sv
`timescale 1ns/1ps

package sim_mem_pkg;
    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        logic [7:0] m;
        m = a[7:0] * 8'd7;
        return m ^ a[15:8] ^ 8'hA5;
    endfunction
endpackage

module sim_bus_model #(parameter bit NARROW = 1'b0) (
    input  logic        clk,
    input  logic        req,
    input  logic [15:0] addr,
    input  logic        stall,
    input  int          lat,
    output logic        gnt,
    output logic        rvalid,
    output logic [15:0] rdata
);
    import sim_mem_pkg::*;
    logic        pend = 1'b0;
    logic [15:0] paddr = '0;
    int          cnt = 0;

    always @(negedge clk) begin
        gnt    = 1'b0;
        rvalid = 1'b0;
        if (pend) begin
            if (cnt <= 1) begin
                rvalid = 1'b1;
                rdata  = NARROW ? {8'h00, mem_byte(paddr)}
                                : {mem_byte(paddr + 16'd1), mem_byte(paddr)};
                pend   = 1'b0;
            end else begin
                cnt = cnt - 1;
            end
        end else if (req && !stall) begin
            gnt   = 1'b1;
            pend  = 1'b1;
            paddr = addr;
            cnt   = lat;
        end
    end
endmodule

module sim_insn_prefetch_queue;
    import sim_mem_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // wide instance
    logic        flush0 = 1'b0;
    logic [15:0] target0 = '0;
    logic        req0, gnt0, rvalid0, valid0;
    logic [15:0] addr0, rdata0;
    logic [7:0]  byte0;
    logic        ready0 = 1'b0;
    logic        stall0 = 1'b1;
    int          lat0 = 1;

    insn_prefetch_queue u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush0), .flush_target(target0),
        .fetch_req(req0), .fetch_addr(addr0), .fetch_gnt(gnt0),
        .fetch_rvalid(rvalid0), .fetch_rdata(rdata0),
        .out_valid(valid0), .out_byte(byte0), .out_ready(ready0)
    );
    sim_bus_model #(.NARROW(1'b0)) bus0 (
        .clk(clk), .req(req0), .addr(addr0), .stall(stall0), .lat(lat0),
        .gnt(gnt0), .rvalid(rvalid0), .rdata(rdata0)
    );

    // narrow instance
    logic        req1, gnt1, rvalid1, valid1;
    logic [15:0] addr1, rdata1;
    logic [7:0]  byte1;
    logic        ready1 = 1'b0;

    insn_prefetch_queue #(.NARROW(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .flush(1'b0), .flush_target(16'h0000),
        .fetch_req(req1), .fetch_addr(addr1), .fetch_gnt(gnt1),
        .fetch_rvalid(rvalid1), .fetch_rdata(rdata1),
        .out_valid(valid1), .out_byte(byte1), .out_ready(ready1)
    );
    sim_bus_model #(.NARROW(1'b1)) bus1 (
        .clk(clk), .req(req1), .addr(addr1), .stall(1'b0), .lat(2),
        .gnt(gnt1), .rvalid(rvalid1), .rdata(rdata1)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // scoreboard for u0
    logic [7:0]  exp_q[$];
    logic [15:0] next_exp = 16'hFFF0;

    task automatic expect_bytes(input int n);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(mem_byte(next_exp));
            next_exp = next_exp + 16'd1;
        end
    endtask

    task automatic drain(input bit toggle);
        int guard;
        guard = 0;
        ready0 = 1'b1;
        while (exp_q.size() != 0 && guard < 3000) begin
            tick();
            if (toggle) ready0 = ~ready0;
            guard++;
        end
        ready0 = 1'b0;
        check(exp_q.size() == 0, "R9 stream drained", exp_q.size(), 0);
    endtask

    task automatic do_flush(input logic [15:0] t);
        flush0 = 1'b1;
        target0 = t;
        tick();
        flush0 = 1'b0;
        exp_q.delete();
        next_exp = t;
    endtask

    always @(negedge clk) begin
        if (rst_n && !flush0 && valid0 && ready0) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected byte", byte0, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(byte0 == e, "R2/R9 byte order", byte0, e);
            end
        end
    end

    // narrow monitor
    logic [15:0] exp1 = 16'hFFF0;
    logic [15:0] req_exp1 = 16'hFFF0;
    logic        prev_req1 = 1'b0;
    int          rises1 = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (valid1 && ready1) begin
                check(byte1 == mem_byte(exp1), "R10 narrow byte", byte1, mem_byte(exp1));
                exp1 = exp1 + 16'd1;
            end
            if (req1 && !prev_req1) begin
                check(addr1 == req_exp1, "R10 narrow address step", addr1, req_exp1);
                req_exp1 = req_exp1 + 16'd1;
                rises1++;
            end
            prev_req1 = req1;
        end
    end

    task automatic wait_req(input string tag);
        int g;
        g = 0;
        do begin
            @(negedge clk);
            #1;
            g++;
        end while (!req0 && g < 100);
        check(req0, tag, req0, 1);
    endtask

    initial begin
        logic [15:0] held;
        int g;
        repeat (5) tick();
        rst_n = 1'b1;
        @(negedge clk);
        check(!valid0, "R1 empty after reset", valid0, 0);
        wait_req("R1 first request raised");
        check(addr0 == 16'hFFF0, "R1 reset address", addr0, 16'hFFF0);

        // streaming, R2 R3 R9
        tick();
        stall0 = 1'b0;
        lat0 = 1;
        expect_bytes(40);
        drain(1'b0);
        lat0 = 3;
        expect_bytes(30);
        drain(1'b1);

        // occupancy limit, R4 and R5
        repeat (30) tick();
        @(negedge clk);
        check(valid0, "R4 queue holds bytes", valid0, 1);
        check(!req0, "R4 no request when full", req0, 0);
        tick();
        stall0 = 1'b1;
        expect_bytes(1);
        ready0 = 1'b1;
        tick();
        ready0 = 1'b0;
        repeat (8) tick();
        @(negedge clk);
        check(!req0, "R4 no request with 5 held", req0, 0);
        tick();
        expect_bytes(1);
        ready0 = 1'b1;
        tick();
        ready0 = 1'b0;
        repeat (3) tick();
        @(negedge clk);
        check(req0, "R4 request with 2 free", req0, 1);
        check(addr0 == next_exp + 16'd4, "R3 request follows held bytes", addr0, next_exp + 16'd4);
        held = addr0;
        repeat (5) tick();
        @(negedge clk);
        check(req0 && addr0 == held, "R5 request held stable", addr0, held);
        tick();
        stall0 = 1'b0;
        expect_bytes(20);
        drain(1'b0);

        // flush with queued bytes, R6
        repeat (20) tick();
        do_flush(16'h1234);
        @(negedge clk);
        check(!valid0, "R6 queue empty after flush", valid0, 0);
        tick();
        expect_bytes(12);
        drain(1'b0);

        // flush with a fetch in flight, R7
        lat0 = 6;
        do_flush(16'h3000);
        g = 0;
        do begin
            @(negedge clk);
            #1;
            g++;
        end while (!gnt0 && g < 100);
        check(gnt0, "R7 grant seen", gnt0, 1);
        tick();
        do_flush(16'h2000);
        wait_req("R7 request after flush");
        check(addr0 == 16'h2000, "R7 restart address", addr0, 16'h2000);
        repeat (30) tick();
        @(negedge clk);
        check(valid0 && byte0 == mem_byte(16'h2000), "R7 stale data discarded", byte0, mem_byte(16'h2000));
        tick();
        expect_bytes(10);
        drain(1'b0);

        // odd target, R8
        lat0 = 1;
        do_flush(16'h4567);
        wait_req("R8 first request");
        check(addr0 == 16'h4566, "R8 aligned first address", addr0, 16'h4566);
        g = 0;
        while (req0 && g < 50) begin @(negedge clk); #1; g++; end
        wait_req("R8 second request");
        check(addr0 == 16'h4568, "R8 realigned address", addr0, 16'h4568);
        repeat (20) tick();
        @(negedge clk);
        check(byte0 == mem_byte(16'h4567), "R8 only high byte kept", byte0, mem_byte(16'h4567));
        tick();
        expect_bytes(12);
        drain(1'b1);

        // narrow build occupancy, R10 (ready1 low since reset)
        check(rises1 == 4, "R10 four fetches fill narrow queue", rises1, 4);
        check(!req1, "R10 narrow idle when full", req1, 0);
        ready1 = 1'b1;
        repeat (100) tick();
        ready1 = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule